// File: doc/BRIEF.md
# Single-Wire Bit-Timing Receiver

This block listens to one open-drain consumer-electronics control line and turns its pulse-width encoded traffic into bytes. One clock is one timing tick (a 32.768 kHz base, about 30.5 µs per tick), and the line is sampled once per tick. All timing is in ticks: the low time of a pulse is the number of ticks the line reads low after a falling edge, and the period of a bit is the number of ticks from its falling edge to the next falling edge.

A message opens with a long start pulse, checked against its own low, high and period windows. Data bits follow. Each bit's value is decided by whether the line is still low at a fixed sample point, and its low time must then fall in the window for that value. Every ten bits form one frame: eight data bits with the most significant first, then an end-of-message flag, then an acknowledge slot. At the close of each frame the block pulses a byte strobe. A window violation, a low that lasts too long, or a message cut off partway through pulses an error strobe, drops the partial frame and makes the receiver search for a start pulse again. Driving the acknowledge slot, arbitration and message buffering belong to neighbouring blocks. Every window limit is a parameter; the defaults below are the millisecond limits rounded to ticks.

Top module: `bitline_rx`

## Requirements
- R1: During and after reset all three strobes are low, and the receiver waits for a falling edge on a line that is high.
- R2: A start pulse is accepted only if its low time is 115 to 128 ticks, checked at the rising edge. A low that reaches 129 ticks raises the error strobe at once.
- R3: At the falling edge that ends the start pulse, its high time must be 20 to 33 ticks and its period 141 to 154 ticks. Otherwise it is an error.
- R4: A data bit is 0 if the line is still low 34 ticks after its falling edge, and 1 otherwise. At its rising edge the low time must be 13 to 26 ticks for a 1 or 43 to 56 ticks for a 0. Otherwise it is an error.
- R5: The period of a data bit, measured at the falling edge of the next bit, must be at least 67 ticks. Otherwise it is an error.
- R6: Each frame is eight data bits with the most significant first, then the end-of-message bit, then the acknowledge bit. The value of the acknowledge bit is not checked. `byte_valid_o` pulses for one cycle, in the cycle after the acknowledge bit's rising edge is sampled, and `byte_o` carries the data byte in that cycle.
- R7: `eom_o` pulses together with `byte_valid_o` exactly when the frame's end-of-message bit was 1.
- R8: A data low that reaches 112 ticks raises the error strobe while the line is still low.
- R9: An error is a one-cycle pulse on `err_o`. It discards the frame in progress and returns the receiver to start-pulse search, so a later valid message is received normally.
- R10: After a data bit, a high time above 92 ticks ends the activity and returns the receiver to idle. This raises no error at a frame boundary and raises an error if the frame is incomplete.
- R11: After an accepted start low, a high time above 33 ticks raises an error without waiting for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one cycle per timing tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronised line level, 1 = released |
| byte_o | output | 8 | Received data byte, valid while `byte_valid_o` is high |
| byte_valid_o | output | 1 | One-cycle strobe at the end of each frame |
| eom_o | output | 1 | One-cycle strobe with `byte_valid_o` when the end-of-message bit is set |
| err_o | output | 1 | One-cycle strobe on any timing violation or truncated frame |

## Verification
Start pulses are swept over low times and high times on both sides of each window, plus pairs whose low and high are each legal but whose period is not; this separates the period check from the separate low and high checks. Data-one and data-zero lows are swept through each window and through the gap between them, so that accepted bits and wrongly classified bits show up as a received byte or an error. Short bit periods, an over-long low seen before release, a message cut off partway, multi-byte messages with different end-of-message and acknowledge values, and recovery after an error each exercise one corner of the frame logic.

// File: rtl/bitline_rx.sv
module bitline_rx #(
  parameter int CW = 9,
  parameter logic [CW-1:0] SL_MIN   = CW'(115),
  parameter logic [CW-1:0] SL_MAX   = CW'(128),
  parameter logic [CW-1:0] SH_MIN   = CW'(20),
  parameter logic [CW-1:0] SH_MAX   = CW'(33),
  parameter logic [CW-1:0] ST_MIN   = CW'(141),
  parameter logic [CW-1:0] ST_MAX   = CW'(154),
  parameter logic [CW-1:0] ONE_MIN  = CW'(13),
  parameter logic [CW-1:0] ONE_MAX  = CW'(26),
  parameter logic [CW-1:0] ZERO_MIN = CW'(43),
  parameter logic [CW-1:0] ZERO_MAX = CW'(56),
  parameter logic [CW-1:0] SAMPLE   = CW'(34),
  parameter logic [CW-1:0] DT_MIN   = CW'(67),
  parameter logic [CW-1:0] END_HIGH = CW'(92),
  parameter logic [CW-1:0] ERR_LOW  = CW'(111)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       eom_o,
  output logic       err_o
);

  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_SLOW, S_SHIGH, S_DLOW, S_DHIGH} st_t;

  st_t           st;
  logic          line_q, late, eom_q;
  logic [CW-1:0] cnt, low_q;
  logic [3:0]    nbit;
  logic [7:0]    shreg;

  wire           fall     = line_q & ~line_i;
  wire           rise     = ~line_q & line_i;
  wire [CW-1:0]  high_now = cnt - low_q;
  wire           one_ok   = (cnt >= ONE_MIN) && (cnt <= ONE_MAX);
  wire           zero_ok  = (cnt >= ZERO_MIN) && (cnt <= ZERO_MAX);
  wire           bit_val  = ~late;

  assign byte_o = shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_q <= 1'b1;
      cnt    <= '0;
    end else begin
      line_q <= line_i;
      if (fall)
        cnt <= CW'(1);
      else if (cnt != CMAX)
        cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st           <= S_IDLE;
      low_q        <= '0;
      late         <= 1'b0;
      eom_q        <= 1'b0;
      nbit         <= '0;
      shreg        <= '0;
      byte_valid_o <= 1'b0;
      eom_o        <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      eom_o        <= 1'b0;
      err_o        <= 1'b0;
      case (st)
        S_IDLE:
          if (fall) st <= S_SLOW;
        S_SLOW:
          if (rise) begin
            if (cnt >= SL_MIN && cnt <= SL_MAX) begin
              low_q <= cnt;
              st    <= S_SHIGH;
            end else begin
              err_o <= 1'b1;
              st    <= S_IDLE;
            end
          end else if (!line_i && cnt > SL_MAX) begin
            err_o <= 1'b1;
            st    <= S_IDLE;
          end
        S_SHIGH:
          if (fall) begin
            if (cnt >= ST_MIN && cnt <= ST_MAX &&
                high_now >= SH_MIN && high_now <= SH_MAX) begin
              st   <= S_DLOW;
              nbit <= '0;
              late <= 1'b0;
            end else begin
              err_o <= 1'b1;
              st    <= S_IDLE;
            end
          end else if (line_i && high_now > SH_MAX) begin
            err_o <= 1'b1;
            st    <= S_IDLE;
          end
        S_DLOW:
          if (rise) begin
            if (late ? zero_ok : one_ok) begin
              st    <= S_DHIGH;
              low_q <= cnt;
              if (nbit < 4'd8) begin
                shreg <= {shreg[6:0], bit_val};
                nbit  <= nbit + 1'b1;
              end else if (nbit == 4'd8) begin
                eom_q <= bit_val;
                nbit  <= 4'd9;
              end else begin
                byte_valid_o <= 1'b1;
                eom_o        <= eom_q;
                nbit         <= '0;
              end
            end else begin
              err_o <= 1'b1;
              st    <= S_IDLE;
            end
          end else if (!line_i) begin
            if (cnt > ERR_LOW) begin
              err_o <= 1'b1;
              st    <= S_IDLE;
            end else if (cnt == SAMPLE) begin
              late <= 1'b1;
            end
          end
        S_DHIGH:
          if (fall) begin
            if (cnt >= DT_MIN) begin
              st   <= S_DLOW;
              late <= 1'b0;
            end else begin
              err_o <= 1'b1;
              st    <= S_IDLE;
            end
          end else if (line_i && high_now > END_HIGH) begin
            st <= S_IDLE;
            if (nbit != 4'd0) err_o <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid_o && err_o));

  a_r7_eom_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    eom_o |-> byte_valid_o);

  a_r6_byte_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> (line_q && !$past(line_q) && nbit == 4'd0));

  a_r9_error_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (st == S_IDLE));

  a_r8_long_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DLOW && !line_i && cnt > ERR_LOW) |=> err_o);

  a_r6_frame_count: assert property (@(posedge clk) disable iff (!rst_n)
    nbit <= 4'd9);

endmodule

// File: tb/bitline_rx_test.sv
module bitline_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic [7:0] bo;
  logic       bv, eo, er;

  int n_chk = 0, n_bad = 0, nb = 0, ne = 0, cyc = 0;
  logic [7:0] gb [0:7];
  logic       ge [0:7];

  bitline_rx uut (.clk(clk), .rst_n(rst_n), .line_i(line),
                  .byte_o(bo), .byte_valid_o(bv), .eom_o(eo), .err_o(er));

  always #4 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bv) begin
        if (nb < 8) begin gb[nb] = bo; ge[nb] = eo; end
        nb++;
      end
      if (er) ne++;
    end
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: got %0d cycles expected below 190000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    repeat (n) begin @(negedge clk); line = v; end
  endtask

  task automatic bitlt(input int low, input int tot);
    hold(1'b0, low); hold(1'b1, tot - low);
  endtask

  task automatic sbit(input logic b);
    bitlt(b ? 20 : 50, 80);
  endtask

  task automatic start(input int l, input int h);
    hold(1'b0, l); hold(1'b1, h);
  endtask

  task automatic frame(input logic [7:0] d, input logic e, input logic a);
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    sbit(e); sbit(a);
  endtask

  task automatic clr();
    nb = 0; ne = 0;
  endtask

  task automatic idle();
    hold(1'b1, 150);
  endtask

  task automatic expect1(input string req, input bit ok, input logic [7:0] d, input logic e);
    if (ok)
      chk(nb == 1 && ne == 0 && gb[0] == d && ge[0] == e, req,
          nb * 65536 + ne * 256 + int'(gb[0]), 65536 + int'(d));
    else
      chk(nb == 0 && ne >= 1, req, nb * 65536 + ne * 256, 256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bv && !eo && !er, "R1 reset strobes", {bv, eo, er}, 0);
    rst_n = 1'b1;
    hold(1'b1, 20);
    chk(nb == 0 && ne == 0 && !bv && !er, "R1 idle after reset", nb + ne, 0);

    // R2: start low sweep, high 26
    for (int l = 108; l <= 135; l++) begin
      clr(); start(l, 26); frame(8'hA5, 1'b1, 1'b0); idle();
      expect1("R2 start low", l >= 115 && l <= 128, 8'hA5, 1'b1);
    end

    // R3 / R11: start high sweep, low 120
    for (int h = 15; h <= 38; h++) begin
      clr(); start(120, h); frame(8'h3C, 1'b0, 1'b1); idle();
      expect1(h > 33 ? "R11 start high timeout" : "R3 start high",
              h >= 21 && h <= 33, 8'h3C, 1'b0);
    end
    for (int li = 0; li < 2; li++)
      for (int hi = 0; hi < 3; hi++) begin
        int l, h, t;
        l = li ? 128 : 115;
        h = (hi == 0) ? 20 : (hi == 1) ? 26 : 33;
        t = l + h;
        clr(); start(l, h); frame(8'h69, 1'b1, 1'b1); idle();
        expect1("R3 start period", t >= 141 && t <= 154, 8'h69, 1'b1);
      end

    // R4: one-low and zero-low sweeps
    for (int l = 8; l <= 40; l++) begin
      clr(); start(120, 26);
      for (int i = 0; i < 8; i++) bitlt(l, 80);
      sbit(1'b1); sbit(1'b0); idle();
      expect1("R4 one low", l >= 13 && l <= 26, 8'hFF, 1'b1);
    end
    for (int l = 38; l <= 62; l++) begin
      clr(); start(120, 26);
      for (int i = 0; i < 8; i++) bitlt(l, 80);
      sbit(1'b0); sbit(1'b0); idle();
      expect1("R4 zero low", l >= 43 && l <= 56, 8'h00, 1'b0);
    end

    // R5: data bit period sweep on the first bit
    for (int t = 60; t <= 74; t++) begin
      clr(); start(120, 26);
      bitlt(20, t);
      for (int i = 6; i >= 0; i--) sbit(1'b0);
      sbit(1'b1); sbit(1'b0); idle();
      expect1("R5 bit period", t >= 67, 8'h80, 1'b1);
    end

    // R6 / R7: multi-byte message, msb first, ack ignored
    clr(); start(120, 26);
    frame(8'h3C, 1'b0, 1'b0); frame(8'h81, 1'b0, 1'b1); frame(8'h5A, 1'b1, 1'b0); idle();
    chk(nb == 3 && ne == 0, "R6 byte count", nb * 256 + ne, 3 * 256);
    chk(gb[0] == 8'h3C, "R6 byte0", gb[0], 8'h3C);
    chk(gb[1] == 8'h81, "R6 byte1", gb[1], 8'h81);
    chk(gb[2] == 8'h5A, "R6 byte2", gb[2], 8'h5A);
    chk(!ge[0] && !ge[1] && ge[2], "R7 eom flags", {ge[0], ge[1], ge[2]}, 1);

    // R8: over-long data low, error before release
    clr(); start(120, 26); sbit(1'b1); sbit(1'b0); sbit(1'b1);
    hold(1'b0, 112); #1;
    chk(ne == 0, "R8 no error at 111 ticks low", ne, 0);
    hold(1'b0, 2); #1;
    chk(ne == 1, "R8 error while low", ne, 1);
    idle();
    chk(ne == 1 && nb == 0, "R9 single error pulse", nb * 256 + ne, 1);

    // R10: truncated frame vs clean end
    clr(); start(120, 26); sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); idle();
    chk(ne == 1 && nb == 0, "R10 truncated frame", nb * 256 + ne, 1);
    clr(); start(120, 26); frame(8'hC3, 1'b1, 1'b0); idle();
    chk(ne == 0 && nb == 1 && gb[0] == 8'hC3, "R10 clean end", nb * 256 + ne, 256);

    // R9: recovery after errors
    clr(); start(100, 26); idle(); start(120, 26); frame(8'h17, 1'b1, 1'b1); idle();
    chk(ne == 1 && nb == 1 && gb[0] == 8'h17, "R9 recover after bad start",
        nb * 65536 + ne * 256 + int'(gb[0]), 65536 + 256 + 8'h17);
    clr(); start(120, 26); sbit(1'b1); bitlt(30, 80); idle();
    start(120, 26); frame(8'hE4, 1'b0, 1'b0); idle();
    chk(ne == 1 && nb == 1 && gb[0] == 8'hE4, "R9 recover after bad bit",
        nb * 65536 + ne * 256 + int'(gb[0]), 65536 + 256 + 8'hE4);

    summary();
  end
endmodule